// File: doc/BRIEF.md
# MDIO Management Command Controller

This block runs one clause-22 management transaction at a time on a two-wire PHY management bus. Software writes a single 32-bit command word. The word holds the operation, the PHY address, the register address and, for a write, the data. The controller serialises the frame on the clock and data pins and, for a read, captures the returned data into the same word. Software reads that word back to see progress and result.

The command word keeps two status bits, both read-only:

- a busy flag, which software polls before and after each command;
- a not-valid flag, which marks a read that the PHY did not answer.

The management clock is derived from the system clock by a parameterised divider and stays low between frames. The data pin is split into an output, an output enable and an input, so it can drive an external tri-state buffer.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: The command word uses these fields: data in [31:16], PHY address in [15:11], register address in [10:6], not-valid flag in bit 4, busy flag in bit 3, and the last accepted operation code in [1:0]. Bits 5 and 2 read as 0.
- R2: A write with [1:0] = 1 starts a write frame and a write with [1:0] = 2 starts a read frame, provided busy is clear. Codes 0 and 3 are ignored and leave the word unchanged.
- R3: Busy reads 1 from the cycle after the command is accepted. It returns to 0 exactly 128*CLK_DIV system clocks after acceptance.
- R4: A write frame, MSB first, is 32 ones, 01, 01, the PHY address, the register address, 10, then the 16 data bits. The data pin is enabled for all 64 bits, and the written data stays in [31:16].
- R5: A read frame drives 32 ones, 01, 10, the PHY address and the register address (46 bits). It then releases the data pin for the two turnaround bits and the 16 data bits.
- R6: When a read finishes, the 16 bits sampled after the turnaround appear in [31:16], MSB first.
- R7: The not-valid flag is set when a read's second turnaround bit samples as 1. It is cleared when the next command is accepted, and it is never set by a write.
- R8: After reset the PHY address field reads the DEFAULT_PHY parameter, and every other bit reads 0.
- R9: A command write that arrives while busy is set is ignored. The running frame and the address fields are unchanged.
- R10: Each half period of the management clock lasts CLK_DIV system clocks. The data pin changes only while that clock is low and is sampled on its rising edge. Between frames the clock is low and the pin is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Command word write strobe |
| reg_wdata | input | 32 | Command word write value |
| reg_rdata | output | 32 | Command/status word read value |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
The hardest situation to reach is a read that the PHY does not answer. Only a silent responder shows it: the turnaround bit is sampled high, and the data field then fills with pull-up ones. The bench's PHY model has a switch that stops it from driving, so such a read runs straight after answered reads. A second awkward case is a command that lands in the middle of a frame. The bench issues it a few dozen cycles into a write, then confirms that only one 64-bit frame with the first command's fields appeared on the pins.

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl #(
  parameter int         CLK_DIV     = 10,
  parameter logic [4:0] DEFAULT_PHY = 5'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int DW       = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int LAST_BIT = 63;
  localparam int TA_HI    = 46;
  localparam int TA_LO    = 47;

  logic [15:0]   data_q, rx_q;
  logic [4:0]    phy_q, reg_q;
  logic [1:0]    op_q;
  logic          busy_q, nvalid_q, mdc_q, oe_q;
  logic [63:0]   tx_q;
  logic [5:0]    bit_q;
  logic [DW-1:0] div_q;

  wire op_ok   = (reg_wdata[1:0] == 2'b01) || (reg_wdata[1:0] == 2'b10);
  wire accept  = reg_wr && !busy_q && op_ok;
  wire tick    = (div_q == DW'(CLK_DIV - 1));
  wire is_read = (op_q == 2'b10);
  wire new_rd  = (reg_wdata[1:0] == 2'b10);

  assign reg_rdata = {data_q, phy_q, reg_q, 1'b0, nvalid_q, busy_q, 1'b0, op_q};
  assign mdc       = mdc_q;
  assign mdio_o    = tx_q[63];
  assign mdio_oe   = oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q   <= '0;
      rx_q     <= '0;
      phy_q    <= DEFAULT_PHY;
      reg_q    <= '0;
      op_q     <= '0;
      busy_q   <= 1'b0;
      nvalid_q <= 1'b0;
      mdc_q    <= 1'b0;
      oe_q     <= 1'b0;
      tx_q     <= '0;
      bit_q    <= '0;
      div_q    <= '0;
    end else if (accept) begin
      data_q   <= reg_wdata[31:16];
      phy_q    <= reg_wdata[15:11];
      reg_q    <= reg_wdata[10:6];
      op_q     <= reg_wdata[1:0];
      busy_q   <= 1'b1;
      nvalid_q <= 1'b0;
      mdc_q    <= 1'b0;
      oe_q     <= 1'b1;
      bit_q    <= '0;
      div_q    <= '0;
      tx_q     <= {32'hFFFF_FFFF, 2'b01, reg_wdata[1:0], reg_wdata[15:11], reg_wdata[10:6],
                   new_rd ? 2'b11 : 2'b10, new_rd ? 16'hFFFF : reg_wdata[31:16]};
    end else if (busy_q) begin
      if (tick) begin
        div_q <= '0;
        mdc_q <= ~mdc_q;
        if (!mdc_q) begin
          if (is_read && bit_q == 6'(TA_LO) && mdio_i) nvalid_q <= 1'b1;
          if (is_read && bit_q > 6'(TA_LO)) rx_q <= {rx_q[14:0], mdio_i};
        end else if (bit_q == 6'(LAST_BIT)) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b0;
          if (is_read) data_q <= rx_q;
        end else begin
          bit_q <= bit_q + 6'd1;
          tx_q  <= {tx_q[62:0], 1'b0};
          if (is_read && bit_q == 6'(TA_HI - 1)) oe_q <= 1'b0;
        end
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  wire busy   = reg_rdata[3];
  wire op_ok  = (reg_wdata[1:0] == 2'b01) || (reg_wdata[1:0] == 2'b10);

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !busy && op_ok |=> reg_rdata[3]); // R2
  AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !busy && !op_ok |=> $stable(reg_rdata)); // R2
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && busy |=> reg_rdata[15:6] == $past(reg_rdata[15:6])); // R9
  AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc && !mdio_oe); // R10
  AST_PIN_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $stable(mdio_o) && $stable(mdio_oe)); // R10
  AST_NVALID_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4] |-> reg_rdata[1:0] == 2'b10); // R7
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk u_chk (.*);

// File: tb/tb_mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_cmd_ctrl;
  localparam int DIV = 2;
  localparam logic [4:0] DEF_PHY = 5'd19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  int k = 64;
  logic [63:0] cap = '0;
  logic [63:0] oecap = '0;
  logic respond = 1'b1;
  logic [15:0] rd_val = '0;

  always #5 clk = ~clk;

  mdio_cmd_ctrl #(.CLK_DIV(DIV), .DEFAULT_PHY(DEF_PHY)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always @(posedge mdc) begin
    if (k < 64) begin
      cap[63-k]   = mdio_o;
      oecap[63-k] = mdio_oe;
    end
    k = k + 1;
  end

  always @(negedge mdc) begin
    if (k == 47) mdio_i = respond ? 1'b0 : 1'b1;
    else if (k >= 48 && k <= 63 && respond) mdio_i = rd_val[63-k];
    else mdio_i = 1'b1;
  end

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (reg_rdata[3] && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] cmd(input logic [15:0] d, input logic [4:0] p, input logic [4:0] r, input logic [1:0] op);
    return {d, p, r, 4'b0000, op};
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual expired expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [4:0] p;
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "reset word", reg_rdata, {16'h0, DEF_PHY, 11'h0});
    check("R10", "reset pins", {mdc, mdio_oe}, 2'b00);

    issue(cmd(16'h1234, 5'd3, 5'd4, 2'b00));
    repeat (10) @(negedge clk);
    check("R2", "op0 ignored", {reg_rdata, mdc}, {16'h0, DEF_PHY, 11'h0, 1'b0});
    issue(cmd(16'h4321, 5'd5, 5'd6, 2'b11));
    repeat (10) @(negedge clk);
    check("R2", "op3 ignored", {reg_rdata, mdc}, {16'h0, DEF_PHY, 11'h0, 1'b0});

    for (int i = 0; i < 32; i++) begin
      p = 5'((i * 7 + 3) % 32);
      d = 16'(i * 16'h0841) ^ 16'hA5C3;
      k = 0;
      issue(cmd(d, p, 5'(i), 2'b01));
      check("R3", "busy after write", reg_rdata[3], 1'b1);
      if (i == 0) begin
        @(posedge mdc);
        n = 0;
        @(negedge clk);
        while (mdc) begin n++; @(negedge clk); end
        check("R10", "mdc high time", n, DIV);
        n = n + 0;
      end
      wait_idle(n);
      if (i != 0) check("R3", "write duration", n, 128 * DIV);
      check("R4", "write frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, p, 5'(i), 2'b10, d});
      check("R4", "write oe", oecap, {64{1'b1}});
      check("R1", "word after write", reg_rdata, {d, p, 5'(i), 6'b000001});

      rd_val = ~d ^ 16'(i);
      respond = 1'b1;
      k = 0;
      issue(cmd(16'h0, p, 5'(i), 2'b10));
      wait_idle(n);
      check("R3", "read duration", n, 128 * DIV);
      check("R5", "read header", cap[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, p, 5'(i)});
      check("R5", "read oe", oecap, {{46{1'b1}}, 18'h0});
      check("R6", "read data", reg_rdata, {rd_val, p, 5'(i), 6'b000010});
    end

    respond = 1'b0;
    k = 0;
    issue(cmd(16'h0, 5'd7, 5'd2, 2'b10));
    wait_idle(n);
    check("R7", "no response read", reg_rdata, {16'hFFFF, 5'd7, 5'd2, 6'b010010});
    respond = 1'b1;
    k = 0;
    issue(cmd(16'hBEEF, 5'd7, 5'd2, 2'b01));
    wait_idle(n);
    check("R7", "write clears flag", reg_rdata, {16'hBEEF, 5'd7, 5'd2, 6'b000001});

    k = 0;
    issue(cmd(16'h5A5A, 5'd11, 5'd22, 2'b01));
    repeat (40) @(negedge clk);
    issue(cmd(16'hC0DE, 5'd30, 5'd9, 2'b10));
    check("R9", "fields during frame", reg_rdata[15:0], {5'd11, 5'd22, 6'b001001});
    wait_idle(n);
    repeat (20) @(negedge clk);
    check("R9", "single frame", k, 64);
    check("R9", "frame kept", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd11, 5'd22, 2'b10, 16'h5A5A});
    check("R9", "word kept", reg_rdata, {16'h5A5A, 5'd11, 5'd22, 6'b000001});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule